// File: doc/BRIEF.md
# Byte Operand Effective Address Unit

This block computes, for the byte-sized operands of one instruction, the memory address each operand refers to and, where the addressing mode changes its base register, the new register value to write back. It serves a CPU with 32-bit general registers. Each operation presents a mode code, the register value selected by decode, and a displacement or absolute field for the source operand. A second, optionally enabled operand channel carries the same information for the destination of a memory-to-memory move. A short base register input supplies the origin for 8-bit absolute addresses.

The block also forms the condition flags for a byte move from the moved byte and the incoming flags. All inputs are taken in on a cycle with `op_valid` high, and every result appears registered on the next cycle, marked by `res_valid`. Decode, the memory bus and the register file are outside the block. When both operands write back to the same register, only one writeback is issued for that register.

Top module: `byte_ea_unit`

## Requirements
- R1: After reset `res_valid`, `src_wb_en` and `dst_wb_en` are 0. A cycle with `op_valid` high produces its results with `res_valid` high exactly one cycle later. An idle cycle yields `res_valid` and both writeback enables at 0 one cycle later.
- R2: Mode 0 (register indirect) uses the register value as the address and requests no writeback.
- R3: Modes 1 (post-increment) and 2 (post-decrement) address at the register value and write back the register plus 1 or minus 1 respectively, modulo 2^32.
- R4: Modes 3 (pre-increment) and 4 (pre-decrement) write back the register plus 1 or minus 1 and use that updated value as the address.
- R5: Mode 5 adds the unsigned value of field bits 1:0 to the register. Mode 6 adds field bits 15:0 sign-extended to 32 bits. Mode 7 adds all 32 field bits. None of these modes writes back.
- R6: Modes 8, 9 and 10 add field bits 15:0, sign-extended, to an index taken from the register. Modes 11, 12 and 13 add the full 32-bit field to that index. In modes 8 and 11 the index is register bits 7:0, zero-extended. In modes 9 and 12 it is register bits 15:0, zero-extended. In modes 10 and 13 it is the full register. No indexed mode writes back.
- R7: Mode 14 forms the address as the short base input plus field bits 7:0, zero-extended. Mode 15 uses field bits 15:0 sign-extended to 32 bits. Mode 16 uses the full 32-bit field. Codes 17 to 31 give address 0 and no writeback.
- R8: `flags_out` is laid out as [4]=H, [3]=N, [2]=Z, [1]=V, [0]=C. N is bit 7 of the moved byte, and Z is 1 when the byte is zero. V is 0. H and C are copied from `flags_in`.
- R9: With `dst_en` high, the destination channel computes its address and writeback exactly as the source channel does. With `dst_en` low, `dst_wb_en` is 0.
- R10: When both channels request a writeback and `src_reg_idx` equals `dst_reg_idx`, only the destination writeback is issued and `src_wb_en` is 0. Otherwise both writebacks are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Inputs hold an operation this cycle |
| src_mode | input | 5 | Source addressing-mode code |
| src_reg_idx | input | 3 | Source register number |
| src_reg_val | input | 32 | Source base or index register value |
| src_field | input | 32 | Source displacement or absolute field |
| dst_en | input | 1 | Destination operand is a memory operand |
| dst_mode | input | 5 | Destination addressing-mode code |
| dst_reg_idx | input | 3 | Destination register number |
| dst_reg_val | input | 32 | Destination base or index register value |
| dst_field | input | 32 | Destination displacement or absolute field |
| short_base | input | 32 | Origin for 8-bit absolute addresses |
| move_byte | input | 8 | Byte being moved |
| flags_in | input | 5 | Current condition flags |
| res_valid | output | 1 | Results below are valid |
| src_ea | output | 32 | Source effective address |
| src_wb_en | output | 1 | Source register writeback request |
| src_wb_val | output | 32 | Source register new value |
| dst_ea | output | 32 | Destination effective address |
| dst_wb_en | output | 1 | Destination register writeback request |
| dst_wb_val | output | 32 | Destination register new value |
| flags_out | output | 5 | Condition flags after the move |

## Verification
Both operand channels can request a writeback in the same cycle. When they name the same register, those two requests collide, and the arbitration rule decides which one survives. The bench provokes this with directed moves that use auto-increment or auto-decrement modes on both operands. Some of these moves name one register for both operands and some name different registers. A randomized phase then draws register numbers from a small set so that collisions occur often. Each cycle, a behavioural model predicts which enables are set and what values they carry, and the bench compares the design against that prediction.

// File: rtl/bea_pkg.sv
package bea_pkg;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    AM_IND     = 5'd0,
    AM_POSTINC = 5'd1,
    AM_POSTDEC = 5'd2,
    AM_PREINC  = 5'd3,
    AM_PREDEC  = 5'd4,
    AM_DISP2   = 5'd5,
    AM_DISP16  = 5'd6,
    AM_DISP32  = 5'd7,
    AM_IDXB16  = 5'd8,
    AM_IDXW16  = 5'd9,
    AM_IDXL16  = 5'd10,
    AM_IDXB32  = 5'd11,
    AM_IDXW32  = 5'd12,
    AM_IDXL32  = 5'd13,
    AM_ABS8    = 5'd14,
    AM_ABS16   = 5'd15,
    AM_ABS32   = 5'd16
  } addr_mode_e;

  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_H = 4;
  localparam int FLG_W = 5;
endpackage

// File: rtl/bea_addr_calc.sv
module bea_addr_calc
  import bea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     reg_val,
  input  logic [AW-1:0]     field,
  input  logic [AW-1:0]     sbase,
  output logic [AW-1:0]     ea,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] fld_s16;
  logic [AW-1:0] fld_z8;
  logic [AW-1:0] fld_z2;
  logic [AW-1:0] idx_b;
  logic [AW-1:0] idx_w;
  logic [AW-1:0] inc_v;
  logic [AW-1:0] dec_v;

  always_comb begin
    fld_s16 = {{(AW-16){field[15]}}, field[15:0]};
    fld_z8  = {{(AW-8){1'b0}}, field[7:0]};
    fld_z2  = {{(AW-2){1'b0}}, field[1:0]};
    idx_b   = {{(AW-8){1'b0}}, reg_val[7:0]};
    idx_w   = {{(AW-16){1'b0}}, reg_val[15:0]};
    inc_v   = reg_val + ONE;
    dec_v   = reg_val - ONE;
  end

  always_comb begin
    ea     = '0;
    wb_en  = 1'b0;
    wb_val = reg_val;
    case (mode)
      AM_IND:     ea = reg_val;
      AM_POSTINC: begin ea = reg_val; wb_en = 1'b1; wb_val = inc_v; end
      AM_POSTDEC: begin ea = reg_val; wb_en = 1'b1; wb_val = dec_v; end
      AM_PREINC:  begin ea = inc_v;   wb_en = 1'b1; wb_val = inc_v; end
      AM_PREDEC:  begin ea = dec_v;   wb_en = 1'b1; wb_val = dec_v; end
      AM_DISP2:   ea = reg_val + fld_z2;
      AM_DISP16:  ea = reg_val + fld_s16;
      AM_DISP32:  ea = reg_val + field;
      AM_IDXB16:  ea = idx_b + fld_s16;
      AM_IDXW16:  ea = idx_w + fld_s16;
      AM_IDXL16:  ea = reg_val + fld_s16;
      AM_IDXB32:  ea = idx_b + field;
      AM_IDXW32:  ea = idx_w + field;
      AM_IDXL32:  ea = reg_val + field;
      AM_ABS8:    ea = sbase + fld_z8;
      AM_ABS16:   ea = fld_s16;
      AM_ABS32:   ea = field;
      default:    ea = '0;
    endcase
  end
endmodule

// File: rtl/bea_flag_gen.sv
module bea_flag_gen
  import bea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]    data,
  input  logic [FLG_W-1:0] flags_in,
  output logic [FLG_W-1:0] flags_out
);
  always_comb begin
    flags_out        = flags_in;
    flags_out[FLG_N] = data[DW-1];
    flags_out[FLG_Z] = (data == '0);
    flags_out[FLG_V] = 1'b0;
  end
endmodule

// File: rtl/byte_ea_unit.sv
module byte_ea_unit
  import bea_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8,
  parameter int RI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        src_mode,
  input  logic [RI-1:0]     src_reg_idx,
  input  logic [AW-1:0]     src_reg_val,
  input  logic [AW-1:0]     src_field,
  input  logic              dst_en,
  input  logic [4:0]        dst_mode,
  input  logic [RI-1:0]     dst_reg_idx,
  input  logic [AW-1:0]     dst_reg_val,
  input  logic [AW-1:0]     dst_field,
  input  logic [AW-1:0]     short_base,
  input  logic [DW-1:0]     move_byte,
  input  logic [4:0]        flags_in,
  output logic              res_valid,
  output logic [AW-1:0]     src_ea,
  output logic              src_wb_en,
  output logic [AW-1:0]     src_wb_val,
  output logic [AW-1:0]     dst_ea,
  output logic              dst_wb_en,
  output logic [AW-1:0]     dst_wb_val,
  output logic [4:0]        flags_out
);
  localparam int NCH = 2;
  localparam int SRC = 0;
  localparam int DST = 1;

  logic [NCH-1:0][MODE_W-1:0] ch_mode;
  logic [NCH-1:0][AW-1:0]     ch_reg;
  logic [NCH-1:0][AW-1:0]     ch_fld;
  logic [NCH-1:0][AW-1:0]     ch_ea;
  logic [NCH-1:0]             ch_wen;
  logic [NCH-1:0][AW-1:0]     ch_wval;
  logic [FLG_W-1:0]           flg_d;

  assign ch_mode[SRC] = src_mode;
  assign ch_mode[DST] = dst_mode;
  assign ch_reg[SRC]  = src_reg_val;
  assign ch_reg[DST]  = dst_reg_val;
  assign ch_fld[SRC]  = src_field;
  assign ch_fld[DST]  = dst_field;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    bea_addr_calc #(.AW(AW)) calc_i (
      .mode    (ch_mode[g]),
      .reg_val (ch_reg[g]),
      .field   (ch_fld[g]),
      .sbase   (short_base),
      .ea      (ch_ea[g]),
      .wb_en   (ch_wen[g]),
      .wb_val  (ch_wval[g])
    );
  end

  bea_flag_gen #(.DW(DW)) flag_i (
    .data      (move_byte),
    .flags_in  (flags_in),
    .flags_out (flg_d)
  );

  // Writeback arbitration: destination wins a same-register collision.
  logic dst_wen_d;
  logic src_wen_d;
  logic same_reg;

  always_comb begin
    same_reg  = (src_reg_idx == dst_reg_idx);
    dst_wen_d = op_valid & dst_en & ch_wen[DST];
    src_wen_d = op_valid & ch_wen[SRC] & ~(dst_wen_d & same_reg);
  end

  // Control state: updated every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      src_wb_en <= 1'b0;
      dst_wb_en <= 1'b0;
    end else begin
      res_valid <= op_valid;
      src_wb_en <= src_wen_d;
      dst_wb_en <= dst_wen_d;
    end
  end

  // Data state: loaded only when an operation is presented.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ea     <= '0;
      src_wb_val <= '0;
      dst_ea     <= '0;
      dst_wb_val <= '0;
      flags_out  <= '0;
    end else if (op_valid) begin
      src_ea     <= ch_ea[SRC];
      src_wb_val <= ch_wval[SRC];
      dst_ea     <= ch_ea[DST];
      dst_wb_val <= ch_wval[DST];
      flags_out  <= flg_d;
    end
  end
endmodule

// File: rtl/bea_checker.sv
module bea_checker #(
  parameter int AW = 32,
  parameter int RI = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [4:0]    src_mode,
  input logic [RI-1:0] src_reg_idx,
  input logic [AW-1:0] src_reg_val,
  input logic [RI-1:0] dst_reg_idx,
  input logic          dst_en,
  input logic [7:0]    move_byte,
  input logic [4:0]    flags_in,
  input logic          res_valid,
  input logic [AW-1:0] src_ea,
  input logic          src_wb_en,
  input logic          dst_wb_en,
  input logic [4:0]    flags_out
);
  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!res_valid && !src_wb_en && !dst_wb_en));
  assert_indirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && src_mode == 5'd0) |=> (src_ea == $past(src_reg_val) && !src_wb_en));
  assert_flag_v_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !flags_out[1]);
  assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flags_out[0] == $past(flags_in[0]) && flags_out[4] == $past(flags_in[4])));
  assert_flag_z_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (flags_out[2] == ($past(move_byte) == 8'h00)));
  assert_dst_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !dst_en) |=> !dst_wb_en);
  assert_single_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && src_wb_en && dst_wb_en) |-> ($past(src_reg_idx) != $past(dst_reg_idx)));
endmodule

bind byte_ea_unit bea_checker #(.AW(AW), .RI(RI)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .src_mode    (src_mode),
  .src_reg_idx (src_reg_idx),
  .src_reg_val (src_reg_val),
  .dst_reg_idx (dst_reg_idx),
  .dst_en      (dst_en),
  .move_byte   (move_byte),
  .flags_in    (flags_in),
  .res_valid   (res_valid),
  .src_ea      (src_ea),
  .src_wb_en   (src_wb_en),
  .dst_wb_en   (dst_wb_en),
  .flags_out   (flags_out)
);

// File: tb/byte_ea_unit_tb_top.sv
module byte_ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  src_mode = '0;
  logic [2:0]  src_reg_idx = '0;
  logic [31:0] src_reg_val = '0;
  logic [31:0] src_field = '0;
  logic        dst_en = 1'b0;
  logic [4:0]  dst_mode = '0;
  logic [2:0]  dst_reg_idx = '0;
  logic [31:0] dst_reg_val = '0;
  logic [31:0] dst_field = '0;
  logic [31:0] short_base = '0;
  logic [7:0]  move_byte = '0;
  logic [4:0]  flags_in = '0;
  logic        res_valid;
  logic [31:0] src_ea;
  logic        src_wb_en;
  logic [31:0] src_wb_val;
  logic [31:0] dst_ea;
  logic        dst_wb_en;
  logic [31:0] dst_wb_val;
  logic [4:0]  flags_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  byte_ea_unit dut_i (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Behavioural reference: returns {wb_en, wb_val, ea}
  function automatic logic [64:0] ref_op(input int m, input logic [31:0] r,
                                         input logic [31:0] f, input logic [31:0] sb);
    longint unsigned a;
    longint signed s16;
    s16 = longint'($signed(f[15:0]));
    case (m)
      0:  return {1'b0, r, r};
      1:  return {1'b1, r + 32'd1, r};
      2:  return {1'b1, r - 32'd1, r};
      3:  return {1'b1, r + 32'd1, r + 32'd1};
      4:  return {1'b1, r - 32'd1, r - 32'd1};
      5:  begin a = longint'(r) + longint'(f % 4); return {1'b0, r, a[31:0]}; end
      6:  begin a = longint'(r) + s16; return {1'b0, r, a[31:0]}; end
      7:  begin a = longint'(r) + longint'(f); return {1'b0, r, a[31:0]}; end
      8:  begin a = longint'(r % 256) + s16; return {1'b0, r, a[31:0]}; end
      9:  begin a = longint'(r % 65536) + s16; return {1'b0, r, a[31:0]}; end
      10: begin a = longint'(r) + s16; return {1'b0, r, a[31:0]}; end
      11: begin a = longint'(r % 256) + longint'(f); return {1'b0, r, a[31:0]}; end
      12: begin a = longint'(r % 65536) + longint'(f); return {1'b0, r, a[31:0]}; end
      13: begin a = longint'(r) + longint'(f); return {1'b0, r, a[31:0]}; end
      14: begin a = longint'(sb) + longint'(f % 256); return {1'b0, r, a[31:0]}; end
      15: begin a = s16; return {1'b0, r, a[31:0]}; end
      16: return {1'b0, r, f};
      default: return {1'b0, r, 32'h0};
    endcase
  endfunction

  // Drive one operation at a falling edge, check one cycle later.
  task automatic run_op(input string rq, input int sm, input logic [2:0] si,
                        input logic [31:0] sr, input logic [31:0] sf,
                        input bit de, input int dm, input logic [2:0] di,
                        input logic [31:0] dr, input logic [31:0] df,
                        input logic [31:0] sb, input logic [7:0] mb, input logic [4:0] fi);
    logic [64:0] es;
    logic [64:0] ed;
    bit sw;
    bit dw;
    logic [4:0] ef;
    op_valid = 1'b1; src_mode = sm[4:0]; src_reg_idx = si; src_reg_val = sr; src_field = sf;
    dst_en = de; dst_mode = dm[4:0]; dst_reg_idx = di; dst_reg_val = dr; dst_field = df;
    short_base = sb; move_byte = mb; flags_in = fi;
    es = ref_op(sm, sr, sf, sb);
    ed = ref_op(dm, dr, df, sb);
    dw = de && ed[64];
    sw = es[64] && !(dw && si == di);
    ef = {fi[4], mb[7], (mb == 8'h00), 1'b0, fi[0]};
    @(negedge clk);
    chk({rq, " res_valid"}, {31'd0, res_valid}, 32'd1);
    chk({rq, " src_ea"}, src_ea, es[31:0]);
    chk({rq, " src_wb_en"}, {31'd0, src_wb_en}, {31'd0, sw});
    if (sw) chk({rq, " src_wb_val"}, src_wb_val, es[63:32]);
    chk({rq, " dst_wb_en"}, {31'd0, dst_wb_en}, {31'd0, dw});
    if (de) chk({rq, " dst_ea"}, dst_ea, ed[31:0]);
    if (dw) chk({rq, " dst_wb_val"}, dst_wb_val, ed[63:32]);
    chk({rq, " flags R8"}, {27'd0, flags_out}, {27'd0, ef});
  endtask

  task automatic idle_chk(input string rq);
    op_valid = 1'b0;
    @(negedge clk);
    chk({rq, " res_valid idle"}, {31'd0, res_valid}, 32'd0);
    chk({rq, " src_wb_en idle"}, {31'd0, src_wb_en}, 32'd0);
    chk({rq, " dst_wb_en idle"}, {31'd0, dst_wb_en}, 32'd0);
  endtask

  localparam logic [31:0] BSRC = 32'h0000_4000;
  localparam logic [31:0] A5 = 32'hA5A5_A5A5;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1 reset src_wb_en", {31'd0, src_wb_en}, 32'd0);
    chk("R1 reset dst_wb_en", {31'd0, dst_wb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'd0, res_valid}, 32'd0);

    run_op("R2 indirect", 0, 3'd1, BSRC, A5, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R3 postinc", 1, 3'd1, BSRC, A5, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b10001);
    run_op("R3 postdec", 2, 3'd1, BSRC, A5, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R3 postinc wrap", 1, 3'd2, 32'hFFFF_FFFF, A5, 0, 0, 3'd0, 0, 0, 0, 8'h80, 5'b00000);
    run_op("R4 preinc", 3, 3'd1, BSRC - 1, A5, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R4 predec", 4, 3'd1, BSRC + 1, A5, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R4 predec wrap", 4, 3'd1, 32'h0, A5, 0, 0, 3'd0, 0, 0, 0, 8'h00, 5'b00000);
    idle_chk("R1");
    run_op("R5 disp2", 5, 3'd1, BSRC - 3, 32'hFFFF_FFFF, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R5 disp16 neg", 6, 3'd1, BSRC + 32'h1234, -32'sd4660, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R5 disp32", 7, 3'd1, BSRC + 32'h10000, 32'hFFFF_0000, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx byte16", 8, 3'd1, 32'hFFFF_FF01, BSRC - 1, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx word16", 9, 3'd1, 32'hFFFF_0002, BSRC - 2, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx long16", 10, 3'd1, 32'h0000_0003, BSRC - 3, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx byte32", 11, 3'd1, 32'hFFFF_FF04, 32'h0012_3400, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx word32", 12, 3'd1, 32'hFFFF_0005, 32'h0012_3400, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R6 idx long32", 13, 3'd1, 32'h0000_0006, 32'h0012_3400, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R7 abs8", 14, 3'd1, A5, 32'h0000_00FF, 0, 0, 3'd0, 0, 0, BSRC - 255, 8'h77, 5'b00000);
    run_op("R7 abs16 high", 15, 3'd1, A5, 32'h0000_8000, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R7 abs16 low", 15, 3'd1, A5, 32'h0000_4000, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R7 abs32", 16, 3'd1, A5, 32'h00FE_DC00, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R7 reserved", 23, 3'd1, A5, 32'h1111_1111, 0, 0, 3'd0, 0, 0, 0, 8'h77, 5'b00000);
    run_op("R8 flags zero", 0, 3'd1, BSRC, 0, 0, 0, 3'd0, 0, 0, 0, 8'h00, 5'b11111);
    run_op("R8 flags neg", 0, 3'd1, BSRC, 0, 0, 0, 3'd0, 0, 0, 0, 8'hFE, 5'b00010);
    run_op("R9 mem2mem postinc", 1, 3'd1, BSRC, 0, 1, 1, 3'd0, 32'h5000, 0, 0, 8'h77, 5'b00000);
    run_op("R9 dst off", 1, 3'd1, BSRC, 0, 0, 1, 3'd0, 32'h5000, 0, 0, 8'h77, 5'b00000);
    run_op("R9 dst disp16", 0, 3'd1, BSRC, 0, 1, 6, 3'd0, 32'h5000, 32'h0000_FFF0, 0, 8'h77, 5'b00000);
    run_op("R10 same reg", 1, 3'd3, BSRC, 0, 1, 4, 3'd3, BSRC, 0, 0, 8'h77, 5'b00000);
    run_op("R10 same reg src only", 2, 3'd3, BSRC, 0, 1, 0, 3'd3, BSRC, 0, 0, 8'h77, 5'b00000);
    idle_chk("R1 end of directed");

    // Randomized phase with frequent register collisions (R3 R4 R9 R10)
    for (int i = 0; i < 300; i++) begin
      run_op("R10 random", $urandom_range(0, 18), 3'($urandom_range(0, 1)), $urandom, $urandom,
             1'($urandom_range(0, 1)), $urandom_range(0, 18), 3'($urandom_range(0, 1)),
             $urandom, $urandom, $urandom, 8'($urandom), 5'($urandom));
      if (i % 37 == 0) idle_chk("R1 random idle");
    end
    op_valid = 1'b0;
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule